// File: doc/BRIEF.md
# Sized Condition Flag Evaluator

This block derives the negative, zero, overflow, carry and extend condition flags for an ALU operation of byte, word or dword size. It then folds them into a status word. The caller supplies the operation class, the operand size, the source, destination and result values, the current status word, an update mask and the current extend flag. One clock later the block returns the new status word.

Carry and overflow come only from the sign bits of the operands and of the result, through a fixed case table. The block never redoes the addition. Subtract and compare use the same table with the source sign inverted and the carry inverted afterwards. Move, logic and shift results carry only sign and zero information. A bit-test class writes its own flags straight into the status word.

The output stage is a small state machine that tracks its own state:
- S_EMPTY is the state after reset, with no result yet.
- S_FRESH means a result was captured on the last edge and `out_vld` is high.
- S_HELD means the last result is being kept.

Any accepted input moves the machine to S_FRESH. Without new input, S_FRESH moves to S_HELD, and S_EMPTY and S_HELD stay where they are.

Top module: `ccflag_eval`

## Requirements
- R1: The operand size code selects the sign bit and the zero test: 0 (byte) uses bit 7 and result bits 7..0; 1 (word) uses bit 15 and bits 15..0; 2 or 3 (dword) uses bit 31 and all 32 bits. Result bits above the size are ignored.
- R2: For add-type (op code 0) with the result sign set, the flags are as follows: N=1; V=1 when both operand signs are clear; otherwise C=1 when both operand signs are set. Z=0.
- R3: For add-type with the result sign clear, the flags are as follows: Z=1 when the sized result is zero; V=1 when both operand signs are set; C=1 when either operand sign is set. N=0.
- R4: For subtract/compare (op code 1), the source is inverted before the table of R2/R3 is applied, and C is inverted afterwards.
- R5: For move/logic/shift (op code 2) of word or dword size, only N (sized sign) and Z (sign clear and sized result zero) can be set. V and C are computed as 0.
- R6: For move/logic/shift of byte size, the add-type table of R2/R3 is used.
- R7: For bit test (op code 3), the bit number is the low 5 bits of `src_i`. N is the selected bit of `dst_i`. Z=1 when that bit and every lower bit are zero. X, N and Z are cleared before N and Z are set. All other bits pass through, and `upd_mask_i` and `x_i` have no effect.
- R8: For bit test with `legacy_i`=1, V and C are cleared as well.
- R9: Flag positions are C bit 0, V bit 1, Z bit 2, N bit 3 and X bit 4. For op codes 0 to 2, only the bits in `upd_mask_i` plus bit 4 take computed values. Every other status bit is copied from `ccs_i`.
- R10: For op codes 0 to 2, when `x_i`=1 and the computed Z is 1, bit 2 is kept from `ccs_i`. When the computed Z is 0, bit 2 is cleared if it is in the mask.
- R11: For op codes 0 to 2, output bit 4 (X) is always 0.
- R12: After reset, `ccs_o` is 0 and `out_vld` is 0. An input with `in_vld`=1 appears on `ccs_o` one edge later with `out_vld`=1. With `in_vld`=0, `ccs_o` holds and `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Inputs valid this cycle |
| op_i | input | 2 | 0 add, 1 sub/compare, 2 move/logic/shift, 3 bit test |
| size_i | input | 2 | 0 byte, 1 word, 2/3 dword |
| src_i | input | 32 | Source operand, or bit number for bit test |
| dst_i | input | 32 | Destination operand, or tested value for bit test |
| res_i | input | 32 | ALU result |
| ccs_i | input | 32 | Incoming status word |
| upd_mask_i | input | 32 | Flag bits allowed to change |
| x_i | input | 1 | Current extend flag |
| legacy_i | input | 1 | Older flag rule for bit test |
| ccs_o | output | 32 | New status word |
| out_vld | output | 1 | `ccs_o` was updated on the last edge |

## Verification
The directed vectors cover the following cases:
- Signed overflow in both directions, separated from unsigned carry by the sign-bit combinations.
- Byte and word results whose upper bits are not zero, which shows that the size selects the sign and zero bits.
- Equal compare and borrow, which shows the source and carry inversion.
- Masked writeback with the extend flag both set and clear, which separates a Z that is kept from a Z that is cleared.

Bit test is exercised at bit 4, bit 7 and bit 31, with the older rule both on and off. A few hundred random vectors over all sizes and classes are compared against a reference model written from the requirements.

// File: rtl/ccfe_pkg.sv
package ccfe_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MOVE = 2'd2,
        OP_BTST = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_DW   = 2'd2,
        SZ_DW2  = 2'd3
    } size_e;

    localparam int FB_C = 0;
    localparam int FB_V = 1;
    localparam int FB_Z = 2;
    localparam int FB_N = 3;
    localparam int FB_X = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;
endpackage

// File: rtl/ccfe_arith_flags.sv
module ccfe_arith_flags
    import ccfe_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e            op,
    input  size_e          size,
    input  logic [W-1:0]   src,
    input  logic [W-1:0]   dst,
    input  logic [W-1:0]   res,
    output flags_t         flags
);
    logic [W-1:0] s_eff;
    logic sgn_s, sgn_d, sgn_r, zr;

    always_comb begin
        // R4: the source is inverted for subtract and compare
        s_eff = (op == OP_SUB) ? ~src : src;
        // R1: the size selects the sign bit and the zero span
        unique case (size)
            SZ_BYTE: begin
                sgn_s = s_eff[7]; sgn_d = dst[7]; sgn_r = res[7];
                zr = (res[7:0] == 8'd0);
            end
            SZ_WORD: begin
                sgn_s = s_eff[15]; sgn_d = dst[15]; sgn_r = res[15];
                zr = (res[15:0] == 16'd0);
            end
            default: begin
                sgn_s = s_eff[W-1]; sgn_d = dst[W-1]; sgn_r = res[W-1];
                zr = (res == '0);
            end
        endcase

        flags = '0;
        if (sgn_r) begin
            // R2: negative result
            flags.n = 1'b1;
            if (!sgn_s && !sgn_d)     flags.v = 1'b1;
            else if (sgn_s && sgn_d)  flags.c = 1'b1;
        end else begin
            // R3: non-negative result
            flags.z = zr;
            flags.v = sgn_s & sgn_d;
            flags.c = sgn_s | sgn_d;
        end
        if (op == OP_SUB) flags.c = ~flags.c;

        // R5: wide move, logic and shift give only N and Z; R6: byte keeps the table
        if (op == OP_MOVE && size != SZ_BYTE) begin
            flags   = '0;
            flags.n = sgn_r;
            flags.z = !sgn_r && zr;
        end
    end
endmodule

// File: rtl/ccfe_bit_test.sv
module ccfe_bit_test
    import ccfe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] ccs_in,
    input  logic         legacy,
    output logic [W-1:0] ccs_out
);
    localparam int IDX_W = $clog2(W);

    logic [IDX_W-1:0] idx;
    logic [W-1:0]     low_mask;
    logic             bit_set, low_zero;

    always_comb begin
        idx      = sel[IDX_W-1:0];
        low_mask = '0;
        for (int k = 0; k < W; k++) begin
            if (k <= int'(idx)) low_mask[k] = 1'b1;
        end
        bit_set  = value[idx];
        low_zero = ((value & low_mask) == '0);

        // R7: clear X, N and Z, then load N and Z
        ccs_out        = ccs_in;
        ccs_out[FB_X]  = 1'b0;
        ccs_out[FB_N]  = bit_set;
        ccs_out[FB_Z]  = low_zero;
        // R8: the older rule also clears V and C
        if (legacy) begin
            ccs_out[FB_V] = 1'b0;
            ccs_out[FB_C] = 1'b0;
        end
    end
endmodule

// File: rtl/ccfe_merge.sv
module ccfe_merge
    import ccfe_pkg::*;
#(
    parameter int W = 32
) (
    input  flags_t       flags,
    input  logic [W-1:0] ccs_in,
    input  logic [W-1:0] mask,
    input  logic         x_cur,
    output logic [W-1:0] ccs_out
);
    logic [W-1:0] eff_mask, fvec;

    always_comb begin
        fvec       = '0;
        fvec[FB_N] = flags.n;
        fvec[FB_Z] = flags.z;
        fvec[FB_V] = flags.v;
        fvec[FB_C] = flags.c;
        // R9 and R11: X is always in the mask and never set in the flag vector
        eff_mask       = mask;
        eff_mask[FB_X] = 1'b1;
        // R10: with extend active, a computed Z may not overwrite the old one
        if (x_cur && flags.z) eff_mask[FB_Z] = 1'b0;
        ccs_out = (ccs_in & ~eff_mask) | (fvec & eff_mask);
    end
endmodule

// File: rtl/ccflag_eval.sv
module ccflag_eval
    import ccfe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [1:0]   op_i,
    input  logic [1:0]   size_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] res_i,
    input  logic [W-1:0] ccs_i,
    input  logic [W-1:0] upd_mask_i,
    input  logic         x_i,
    input  logic         legacy_i,
    output logic [W-1:0] ccs_o,
    output logic         out_vld
);
    typedef enum logic [1:0] { S_EMPTY, S_FRESH, S_HELD } st_e;

    st_e          st_q, st_d;
    op_e          op;
    size_e        size;
    flags_t       aflags;
    logic [W-1:0] merged, tested, ccs_next, ccs_q;

    assign op   = op_e'(op_i);
    assign size = size_e'(size_i);

    ccfe_arith_flags #(.W(W)) u_arith (
        .op(op), .size(size), .src(src_i), .dst(dst_i), .res(res_i), .flags(aflags)
    );

    ccfe_merge #(.W(W)) u_merge (
        .flags(aflags), .ccs_in(ccs_i), .mask(upd_mask_i), .x_cur(x_i), .ccs_out(merged)
    );

    ccfe_bit_test #(.W(W)) u_btst (
        .value(dst_i), .sel(src_i), .ccs_in(ccs_i), .legacy(legacy_i), .ccs_out(tested)
    );

    assign ccs_next = (op == OP_BTST) ? tested : merged;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_EMPTY: st_d = in_vld ? S_FRESH : S_EMPTY;
            S_FRESH: st_d = in_vld ? S_FRESH : S_HELD;
            S_HELD:  st_d = in_vld ? S_FRESH : S_HELD;
            default: st_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ccs_q <= '0;
        else if (in_vld) ccs_q <= ccs_next;
    end

    assign ccs_o   = ccs_q;
    assign out_vld = (st_q == S_FRESH);

    p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(ccs_o) && !out_vld));
    p_x_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_i != 2'd3) |=> !ccs_o[FB_X]);
    p_unmasked_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_i != 2'd3) |=>
            (((ccs_o ^ $past(ccs_i)) & ~($past(upd_mask_i) | (W'(1) << FB_X))) == '0));
    p_sticky_z_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_i != 2'd3 && x_i && !ccs_i[FB_Z]) |=> !ccs_o[FB_Z]);
    p_btst_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_i == 2'd3 && !legacy_i) |=>
            (ccs_o[FB_V] == $past(ccs_i[FB_V]) && ccs_o[FB_C] == $past(ccs_i[FB_C])
             && ccs_o[W-1:FB_X+1] == $past(ccs_i[W-1:FB_X+1])));
    p_btst_legacy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_i == 2'd3 && legacy_i) |=> (!ccs_o[FB_V] && !ccs_o[FB_C]));
endmodule

// File: tb/test_ccflag_eval.sv
module test_ccflag_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [1:0]  op_i = '0, size_i = '0;
    logic [31:0] src_i = '0, dst_i = '0, res_i = '0, ccs_i = '0, upd_mask_i = '0;
    logic        x_i = 1'b0, legacy_i = 1'b0;
    logic [31:0] ccs_o;
    logic        out_vld;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ccflag_eval i_ccflag_eval (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_i(op_i), .size_i(size_i),
        .src_i(src_i), .dst_i(dst_i), .res_i(res_i), .ccs_i(ccs_i),
        .upd_mask_i(upd_mask_i), .x_i(x_i), .legacy_i(legacy_i),
        .ccs_o(ccs_o), .out_vld(out_vld)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  sz;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] res;
        logic [31:0] ccs;
        logic [31:0] mask;
        logic        x;
        logic        leg;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd2, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h10, 32'h1F, 1'b0, 1'b0, 32'h0A, 8'd2},       // R2 overflow
        '{2'd0, 2'd2, 32'h80000000, 32'h80000000, 32'h00000000, 32'h00, 32'h1F, 1'b0, 1'b0, 32'h07, 8'd3},       // R3
        '{2'd0, 2'd0, 32'h000000FF, 32'h00000001, 32'h00000100, 32'hFFFFFF00, 32'h1F, 1'b0, 1'b0, 32'hFFFFFF05, 8'd1}, // R1 byte
        '{2'd0, 2'd1, 32'h00008000, 32'h00008000, 32'h00018000, 32'h00, 32'h1F, 1'b0, 1'b0, 32'h09, 8'd1},       // R1 word
        '{2'd1, 2'd2, 32'h00000001, 32'h00000001, 32'h00000000, 32'h00, 32'h1F, 1'b0, 1'b0, 32'h04, 8'd4},       // R4 equal
        '{2'd1, 2'd2, 32'h00000001, 32'h00000000, 32'hFFFFFFFF, 32'h00, 32'h1F, 1'b0, 1'b0, 32'h09, 8'd4},       // R4 borrow
        '{2'd2, 2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00008000, 32'h03, 32'h1F, 1'b0, 1'b0, 32'h08, 8'd5},       // R5
        '{2'd2, 2'd0, 32'h00000000, 32'h00000000, 32'h00000080, 32'h00, 32'h1F, 1'b0, 1'b0, 32'h0A, 8'd6},       // R6
        '{2'd0, 2'd2, 32'h80000000, 32'h80000000, 32'h00000000, 32'h18, 32'h01, 1'b0, 1'b0, 32'h09, 8'd9},       // R9
        '{2'd0, 2'd2, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00, 32'h1F, 1'b1, 1'b0, 32'h00, 8'd10},      // R10 no new Z
        '{2'd0, 2'd2, 32'h00000000, 32'h00000000, 32'h00000000, 32'h04, 32'h1F, 1'b1, 1'b0, 32'h04, 8'd10},      // R10 Z kept
        '{2'd0, 2'd2, 32'h00000000, 32'h00000000, 32'h00000005, 32'h14, 32'h1F, 1'b1, 1'b0, 32'h00, 8'd10},      // R10 Z cleared
        '{2'd3, 2'd2, 32'h00000004, 32'h00000010, 32'h0, 32'h1F, 32'h00, 1'b0, 1'b0, 32'h0B, 8'd7},             // R7 bit 4
        '{2'd3, 2'd2, 32'h00000007, 32'hFFFFFF00, 32'h0, 32'hF000001F, 32'h00, 1'b1, 1'b1, 32'hF0000004, 8'd8}, // R8
        '{2'd3, 2'd2, 32'h0000003F, 32'h80000000, 32'h0, 32'h00, 32'hFF, 1'b0, 1'b0, 32'h08, 8'd7},             // R7 bit 31
        '{2'd2, 2'd2, 32'h0, 32'h0, 32'h00000001, 32'hABCD0010, 32'h00, 1'b0, 1'b0, 32'hABCD0000, 8'd11}        // R11
    };

    function automatic logic [31:0] ref_model(logic [1:0] op, logic [1:0] sz,
            logic [31:0] s, logic [31:0] d, logic [31:0] r, logic [31:0] ccs,
            logic [31:0] mask, logic x, logic leg);
        int sb;
        logic ss, ds, rs, rz, n, z, v, c;
        logic [31:0] em, f, o;
        sb = (sz == 2'd0) ? 7 : (sz == 2'd1) ? 15 : 31;
        if (op == 2'd3) begin
            int b;
            b = int'(s[4:0]);
            o = ccs & ~32'h1C;
            if (leg) o = o & ~32'h3;
            o[3] = d[b];
            o[2] = 1'b1;
            for (int k = 0; k <= b; k++) if (d[k]) o[2] = 1'b0;
            return o;
        end
        if (op == 2'd1) s = ~s;
        ss = s[sb]; ds = d[sb]; rs = r[sb];
        rz = 1'b1;
        for (int k = 0; k <= sb; k++) if (r[k]) rz = 1'b0;
        n = 0; z = 0; v = 0; c = 0;
        if (op == 2'd2 && sz != 2'd0) begin
            n = rs; z = !rs && rz;
        end else begin
            if (rs) begin
                n = 1; v = !ss && !ds; c = ss && ds && !v;
            end else begin
                z = rz; v = ss && ds; c = ss || ds;
            end
            if (op == 2'd1) c = !c;
        end
        f  = {28'd0, n, z, v, c};
        em = mask | 32'h10;
        if (x && z) em[2] = 1'b0;
        return (ccs & ~em) | (f & em);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] op, logic [1:0] sz, logic [31:0] s, logic [31:0] d,
            logic [31:0] r, logic [31:0] ccs, logic [31:0] mask, logic x, logic leg);
        @(negedge clk);
        op_i = op; size_i = sz; src_i = s; dst_i = d; res_i = r;
        ccs_i = ccs; upd_mask_i = mask; x_i = x; legacy_i = leg; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R12: state after reset
        check("R12 reset ccs", ccs_o, 32'h0);
        check("R12 reset vld", {31'd0, out_vld}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].sz, VECS[i].src, VECS[i].dst, VECS[i].res,
                  VECS[i].ccs, VECS[i].mask, VECS[i].x, VECS[i].leg);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), ccs_o, VECS[i].exp);
        end

        // R12: one-edge latency, then hold
        apply(2'd0, 2'd2, 32'h1, 32'h1, 32'h2, 32'h0, 32'h1F, 1'b0, 1'b0);
        check("R12 vld after input", {31'd0, out_vld}, 32'h1);
        held = ccs_o;
        src_i = 32'h80000000; dst_i = 32'h80000000; res_i = 32'h0;
        @(negedge clk);
        @(negedge clk);
        check("R12 hold ccs", ccs_o, held);
        check("R12 hold vld", {31'd0, out_vld}, 32'h0);

        // R1 R2 R3 R4 R5 R6 R9 R10 R11: random against the reference model
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  op, sz;
            logic [31:0] s, d, r, ccs, m;
            logic        x, leg;
            op  = 2'($urandom_range(0, 3));
            sz  = 2'($urandom_range(0, 3));
            s   = $urandom; d = $urandom; r = $urandom;
            if (i % 4 == 0) r = r & 32'hFFFF0000;
            if (i % 8 == 1) r = r & 32'hFFFFFF00;
            ccs = $urandom; m = $urandom;
            x   = 1'($urandom_range(0, 1)); leg = 1'($urandom_range(0, 1));
            apply(op, sz, s, d, r, ccs, m, x, leg);
            check($sformatf("R1/op%0d random %0d", op, i), ccs_o,
                  ref_model(op, sz, s, d, r, ccs, m, x, leg));
        end

        // R12: reset again clears the output
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 rereset", ccs_o, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule